// File: doc/BRIEF.md
# Stream Traffic Statistics Snapshotter

This block sits beside a valid/ready data stream and tallies the bytes and the frames that complete a handshake on it. It only listens. Every monitored signal is an input, and it drives nothing back toward that stream. The monitored data bus itself is not needed, because only the byte-enable lanes, the handshake pair and the end-of-frame marker affect the counts.

A single-cycle trigger pulse does two things. It freezes the running totals into a snapshot register, and it restarts the counters. The snapshot is then sent as one short frame on an 8-bit valid/ready output, together with a tag word taken in the same cycle. Because the output is byte-wide, the frames from several of these blocks that share one trigger can be merged into one larger record further downstream. Counting never stops while a snapshot is being sent.

Top module: `stream_stat_counter`

## Requirements
- R1: After reset, `snapValid` and `snapLast` are low, and both running counters are zero.
- R2: On every cycle where `monValid` and `monReady` are both high, the byte counter grows by the number of set bits in `monKeep`. A cycle with only one of the two high adds nothing.
- R3: The frame counter grows by one on every cycle where `monValid`, `monReady` and `monLast` are all high.
- R4: A trigger taken while no snapshot is pending raises `snapValid` on the next cycle. The frame is TAG_BYTES tag bytes, then 4 bytes of the byte count, then 4 bytes of the frame count. Each field is sent least significant byte first, and `snapLast` is high only on the final byte.
- R5: The snapshot holds the totals up to the cycle before the trigger. A beat that completes in the trigger cycle is counted into the new interval.
- R6: A trigger that arrives while `snapValid` is high is ignored. No extra frame is produced and the counters are not cleared.
- R7: While `snapValid` is high and `snapReady` is low, `snapData` and `snapLast` hold their values. The frame advances one byte per accepted transfer.
- R8: Beats that complete while a snapshot is being sent are counted into the current interval.
- R9: In the cycle after the final byte is accepted, `snapValid` is low, and it stays low until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| monKeep | input | KEEP_W | Byte-lane enables of the monitored stream |
| monValid | input | 1 | Valid of the monitored stream |
| monReady | input | 1 | Ready of the monitored stream (observed only) |
| monLast | input | 1 | End-of-frame of the monitored stream |
| tagIn | input | 8*TAG_BYTES | Tag word captured with the snapshot |
| trigger | input | 1 | Snapshot-and-clear request |
| snapData | output | 8 | Snapshot frame byte |
| snapValid | output | 1 | Snapshot byte valid |
| snapReady | input | 1 | Downstream ready for snapshot bytes |
| snapLast | output | 1 | Final byte of the snapshot frame |

## Verification
A wrong lane count or a miscounted frame stays hidden inside the counters until the next trigger. It then appears as a wrong byte in the count fields, in the first frame sent after the fault. A shift register that moves on without a handshake shows at once as a byte out of order while `snapReady` is low. A control state that fails to clear the counters, or accepts a trigger while a frame is pending, surfaces as an extra frame or as totals that are too large in the frame after that. For this reason the bench always follows a stimulus phase with a further trigger.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int CNT_W = 32;
  localparam int CNT_BYTES = CNT_W / 8;

  typedef struct packed {
    logic capture;   // latch totals + tag, restart counters
    logic advance;   // one snapshot byte accepted downstream
  } stat_ctrl_t;
endpackage

// File: rtl/stat_popcount.sv
module stat_popcount #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import stat_pkg::*;
#(
  parameter int KEEP_W = 8,
  parameter int TAG_BYTES = 2,
  localparam int TAG_W = 8 * TAG_BYTES,
  localparam int SNAP_W = TAG_W + 2 * CNT_W,
  localparam int POP_W = $clog2(KEEP_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEEP_W-1:0] monKeep,
  input  logic              monValid,
  input  logic              monReady,
  input  logic              monLast,
  input  logic [TAG_W-1:0]  tagIn,
  input  stat_ctrl_t        ctrl,
  output logic [7:0]        outByte
);
  logic [POP_W-1:0] laneCount;
  logic             beatFire;
  logic [CNT_W-1:0] byteInc;
  logic [CNT_W-1:0] frameInc;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] frameCnt;
  logic [SNAP_W-1:0] snapReg;

  stat_popcount #(.W(KEEP_W)) popcount_i (
    .bits  (monKeep),
    .count (laneCount)
  );

  assign beatFire = monValid & monReady;
  assign byteInc  = beatFire ? CNT_W'(laneCount) : '0;
  assign frameInc = CNT_W'(beatFire & monLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt  <= '0;
      frameCnt <= '0;
    end else if (ctrl.capture) begin
      byteCnt  <= byteInc;
      frameCnt <= frameInc;
    end else begin
      byteCnt  <= byteCnt + byteInc;
      frameCnt <= frameCnt + frameInc;
    end
  end

  // Snapshot is laid out so that a right shift emits bytes in frame order.
  always_ff @(posedge clk) begin
    if (rst) begin
      snapReg <= '0;
    end else if (ctrl.capture) begin
      snapReg <= {frameCnt, byteCnt, tagIn};
    end else if (ctrl.advance) begin
      snapReg <= snapReg >> 8;
    end
  end

  assign outByte = snapReg[7:0];
endmodule

// File: rtl/stat_control.sv
module stat_control
  import stat_pkg::*;
#(
  parameter int FRAME_BYTES = 10,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trigger,
  input  logic       outReady,
  output logic       outValid,
  output logic       outLast,
  output stat_ctrl_t ctrl
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             atLast;
  logic             xfer;

  assign atLast        = (idx == IDX_W'(FRAME_BYTES - 1));
  assign xfer          = (state == ST_SEND) & outReady;
  assign ctrl.capture  = (state == ST_IDLE) & trigger;
  assign ctrl.advance  = xfer;
  assign outValid      = (state == ST_SEND);
  assign outLast       = (state == ST_SEND) & atLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            state <= ST_SEND;
            idx   <= '0;
          end
        end
        ST_SEND: begin
          if (xfer) begin
            if (atLast) begin
              state <= ST_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_stat_counter.sv
module stream_stat_counter
  import stat_pkg::*;
#(
  parameter int KEEP_W = 8,
  parameter int TAG_BYTES = 2,
  localparam int TAG_W = 8 * TAG_BYTES,
  localparam int FRAME_BYTES = TAG_BYTES + 2 * CNT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEEP_W-1:0] monKeep,
  input  logic              monValid,
  input  logic              monReady,
  input  logic              monLast,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic              trigger,
  output logic [7:0]        snapData,
  output logic              snapValid,
  input  logic              snapReady,
  output logic              snapLast
);
  stat_ctrl_t ctrl;

  stat_control #(.FRAME_BYTES(FRAME_BYTES)) control_i (
    .clk      (clk),
    .rst      (rst),
    .trigger  (trigger),
    .outReady (snapReady),
    .outValid (snapValid),
    .outLast  (snapLast),
    .ctrl     (ctrl)
  );

  stat_datapath #(.KEEP_W(KEEP_W), .TAG_BYTES(TAG_BYTES)) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .monKeep  (monKeep),
    .monValid (monValid),
    .monReady (monReady),
    .monLast  (monLast),
    .tagIn    (tagIn),
    .ctrl     (ctrl),
    .outByte  (snapData)
  );
endmodule

// File: rtl/stream_stat_counter_chk.sv
module stream_stat_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       trigger,
  input logic [7:0] snapData,
  input logic       snapValid,
  input logic       snapReady,
  input logic       snapLast
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    snapValid && !snapReady |=> snapValid && $stable(snapData) && $stable(snapLast));

  assert_trigger_starts_R4: assert property (@(posedge clk) disable iff (rst)
    trigger && !snapValid |=> snapValid);

  assert_last_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    snapLast |-> snapValid);

  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    snapValid && snapReady && snapLast |=> !snapValid);

  assert_no_spontaneous_R9: assert property (@(posedge clk) disable iff (rst)
    !snapValid && !trigger |=> !snapValid);
endmodule

bind stream_stat_counter stream_stat_counter_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .trigger   (trigger),
  .snapData  (snapData),
  .snapValid (snapValid),
  .snapReady (snapReady),
  .snapLast  (snapLast)
);

// File: tb/stream_stat_counter_tb_top.sv
module stream_stat_counter_tb_top;
  localparam int KEEP_W = 8;
  localparam int TAG_BYTES = 2;
  localparam int TAG_W = 8 * TAG_BYTES;
  localparam int FRAME_BYTES = TAG_BYTES + 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic [KEEP_W-1:0] monKeep;
  logic              monValid, monReady, monLast;
  logic [TAG_W-1:0]  tagIn;
  logic              trigger;
  logic [7:0]        snapData;
  logic              snapValid, snapReady, snapLast;

  stream_stat_counter #(.KEEP_W(KEEP_W), .TAG_BYTES(TAG_BYTES)) dut_i (
    .clk(clk), .rst(rst), .monKeep(monKeep), .monValid(monValid),
    .monReady(monReady), .monLast(monLast), .tagIn(tagIn), .trigger(trigger),
    .snapData(snapData), .snapValid(snapValid), .snapReady(snapReady),
    .snapLast(snapLast)
  );

  typedef struct {
    logic [7:0] data;
    bit         last;
    string      req;
  } exp_t;

  exp_t        expQ[$];
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 0;
  logic [31:0] mBytes = '0;
  logic [31:0] mFrames = '0;

  function automatic int popc(logic [KEEP_W-1:0] k);
    int n = 0;
    for (int i = 0; i < KEEP_W; i++) n += int'(k[i]);
    return n;
  endfunction

  task automatic pushFrame(logic [31:0] b, logic [31:0] f, logic [TAG_W-1:0] t, string req);
    logic [TAG_W+63:0] word;
    word = {f, b, t};
    for (int i = 0; i < FRAME_BYTES; i++) begin
      exp_t e;
      e.data = word[8*i +: 8];
      e.last = (i == FRAME_BYTES - 1);
      e.req  = req;
      expQ.push_back(e);
    end
  endtask

  // Driver: one clock of stimulus; updates the reference totals.
  task automatic step(logic [KEEP_W-1:0] k, bit v, bit rdy, bit l, bit trg, bit ordy, string req);
    int inc;
    int finc;
    @(negedge clk);
    monKeep = k; monValid = v; monReady = rdy; monLast = l;
    trigger = trg; snapReady = ordy;
    inc  = (v && rdy) ? popc(k) : 0;
    finc = (v && rdy && l) ? 1 : 0;
    if (trg && !snapValid) begin
      pushFrame(mBytes, mFrames, tagIn, req);
      mBytes  = 32'(inc);
      mFrames = 32'(finc);
    end else begin
      mBytes  = mBytes + 32'(inc);
      mFrames = mFrames + 32'(finc);
    end
  endtask

  task automatic drain(string req);
    int n = 0;
    while ((expQ.size() != 0 || snapValid) && n < 400) begin
      step('0, 0, 0, 0, 0, (n % 3) != 1, req);
      n++;
    end
    step('0, 0, 0, 0, 0, 1, req);
  endtask

  // Monitor: compares each accepted snapshot byte with the scoreboard.
  always @(negedge clk) begin
    #1;
    if (!rst && snapValid && snapReady) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R6: unexpected snapshot byte %02h (last=%0b), expected none", snapData, snapLast);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (snapData !== e.data || snapLast !== e.last) begin
          miscompares++;
          $display("FAIL %s: byte %02h last %0b, expected %02h last %0b",
                   e.req, snapData, snapLast, e.data, e.last);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; monKeep = '0; monValid = 0; monReady = 0; monLast = 0;
    trigger = 0; snapReady = 0; tagIn = 16'hBEEF;
    repeat (4) @(negedge clk);
    rst = 0;
    step('0, 0, 0, 0, 0, 1, "R1");
    // R1: idle outputs after reset
    vectors++;
    if (snapValid !== 1'b0 || snapLast !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: valid %0b last %0b, expected 0 0", snapValid, snapLast);
    end
    // R1/R4: empty interval snapshot, field order and last marker
    step('0, 0, 0, 0, 1, 1, "R1");
    drain("R4");

    // R2/R3: lane counting, handshake qualification
    tagIn = 16'h1234;
    step(8'hFF, 1, 1, 0, 0, 1, "R2");
    step(8'h0F, 1, 1, 0, 0, 1, "R2");
    step(8'h01, 1, 1, 1, 0, 1, "R3");
    step(8'hFF, 1, 0, 1, 0, 1, "R2");   // valid without ready
    step(8'hFF, 0, 1, 1, 0, 1, "R2");   // ready without valid
    step(8'hA5, 1, 1, 1, 0, 1, "R3");
    step(8'h80, 1, 1, 0, 0, 1, "R2");
    step('0, 0, 0, 0, 1, 1, "R2");
    drain("R3");

    // R5: beat in the trigger cycle belongs to the new interval
    tagIn = 16'h5A5A;
    step(8'h03, 1, 1, 1, 0, 1, "R5");
    step(8'h3C, 1, 1, 1, 1, 1, "R5");
    drain("R5");
    step(8'hC0, 1, 1, 0, 0, 1, "R5");
    step('0, 0, 0, 0, 1, 1, "R5");
    drain("R5");

    // R7/R8/R6: backpressure, counting during send, ignored trigger
    tagIn = 16'h00C3;
    step(8'h7F, 1, 1, 1, 1, 0, "R7");
    for (int i = 0; i < 14; i++) begin
      step(8'h11 << (i % 4), 1, (i % 5) != 2, i[0], (i == 6), (i % 3) == 0, "R8");
    end
    drain("R7");
    tagIn = 16'h9001;
    step('0, 0, 0, 0, 1, 1, "R6");
    drain("R6");

    // R9: no frame without a trigger
    for (int i = 0; i < 4; i++) begin
      step(8'hFF, 1, 1, 1, 0, 1, "R9");
      vectors++;
      if (snapValid !== 1'b0) begin
        miscompares++;
        $display("FAIL R9: valid %0b, expected 0", snapValid);
      end
    end
    step('0, 0, 0, 0, 1, 1, "R9");
    drain("R9");

    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R4: %0d bytes never sent, expected 0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule